// File: doc/BRIEF.md
# Fundamental-Reset Power-Up Sequencer

This block brings a root port's card slot out of fundamental reset in a safe order. A start request switches the slot supply on. Once the supply reports stable, the reference clock is switched on. When the clock reports stable, a single hold interval is counted, and then the active-low card reset is released. The hold interval is the longer of two minimum delays. One is measured from supply stable (100 ms by default) and the other from clock stable (100 us by default). The timer starts only after the clock is stable, and by then the supply is already stable, so one count meets both limits.

A fault on either status input during the sequence pulls the reset low in the same cycle and sends the sequence back to waiting for the supply. If a status input never asserts after its enable, a sticky timeout is raised, both enables are turned off and the card stays in reset until the block itself is reset. All delays are parameters given in microseconds and converted to cycles of the system clock, rounded up. The status inputs are taken to be already synchronous to `clk`.

Top module: `fundrst_powerup_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, and in the cycle after that edge, `perst_n_o`, `pwr_en_o`, `refclk_en_o`, `done_o` and `timeout_o` are all 0.
- R2: A `start_req` sampled high in the idle state sets `pwr_en_o` from the next cycle. `refclk_en_o` stays 0 for as long as `pwr_good_i` has not been sampled high.
- R3: In the supply-wait state, `refclk_en_o` rises in the cycle after the edge that first samples `pwr_good_i` high.
- R4: HOLD = max(supply delay, clock delay) in cycles. The first cycle after the edge that samples `refclk_ok_i` high in the clock-wait state is hold cycle 1. `perst_n_o` stays 0 through hold cycle HOLD and goes to 1 in the following cycle.
- R5: `perst_n_o` is 0 in any cycle where `pwr_good_i` or `refclk_ok_i` is low, including the very cycle in which it falls.
- R6: After an edge samples either status input low during the clock wait, the hold or the released state, the block returns to the supply-wait state. In that state `pwr_en_o` is 1 and `refclk_en_o` is 0. The hold count restarts from zero, and a full HOLD is counted again after the clock is next seen stable.
- R7: If `pwr_good_i` stays low for TMO cycles after `pwr_en_o` rises, then from the next cycle `timeout_o` is 1 and both enables and `perst_n_o` are 0. This state holds, and `start_req` and the status inputs are ignored, until `rst_n` is low.
- R8: If `refclk_ok_i` stays low for TMO cycles after `refclk_en_o` rises, the block enters the same sticky timeout state described in R7.
- R9: `done_o` is 1 exactly when `perst_n_o` is 1. It stays 1 until reset or until a status input is lost.
- R10: A `start_req` that arrives while a sequence is running has no effect on the outputs or on the timing of the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_req | input | 1 | Begins a power-up sequence when the block is idle |
| pwr_good_i | input | 1 | Slot supply reports stable |
| refclk_ok_i | input | 1 | Reference clock reports stable |
| pwr_en_o | output | 1 | Switches the slot supply on |
| refclk_en_o | output | 1 | Switches the reference clock on |
| perst_n_o | output | 1 | Card fundamental reset, low = held in reset |
| done_o | output | 1 | Reset has been released |
| timeout_o | output | 1 | Sticky: a status input never asserted |

## Verification
A sequencer state that is wrong, or a hold counter that is not cleared, shows up at the ports as a release of `perst_n_o` on the wrong cycle. An early release of one cycle is caught by a check placed on the last hold cycle. A counter that was never cleared releases many cycles early, at the point where the first hold would have ended. A wrong next state after a fault shows as an enable pattern that is wrong in the very next cycle. A timeout counter that misses its limit by one shows up exactly one cycle away from where the bench expects `timeout_o`. A lost status input that still lets the reset stay high is seen in the same cycle, because the bench samples `perst_n_o` in the cycle the input falls.

// File: rtl/fundrst_pkg.sv
// Package: shared state encoding and the microsecond-to-cycle conversion
// for the fundamental-reset power-up sequencer.
// Assumes: the clock frequency is given in Hz and does not exceed 2^32-1.
package fundrst_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE     = 3'd0,
        SEQ_PWR_WAIT = 3'd1,
        SEQ_CLK_WAIT = 3'd2,
        SEQ_HOLD     = 3'd3,
        SEQ_RUN      = 3'd4,
        SEQ_FAULT    = 3'd5
    } seq_state_e;

    // Converts a delay in microseconds to cycles, rounded up, never zero.
    function automatic int unsigned us_to_cycles(input int unsigned hz,
                                                 input int unsigned us);
        longint unsigned t;
        t = (longint'(hz) * longint'(us) + 64'd999_999) / 64'd1_000_000;
        if (t == 64'd0) t = 64'd1;
        return int'(t);
    endfunction

endpackage

// File: rtl/seq_cnt.sv
// Module: seq_cnt - interval counter for the sequencer.
// Counts the cycles in which run is high and returns to zero in any cycle
// where run is low. expired is high in the LIMIT-th consecutive run cycle.
// Assumes: LIMIT >= 1, the synchronous reset is active low.
module seq_cnt #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int unsigned W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    // Advance while running, otherwise hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (!run)    cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    // Expiry flag, seen by the sequencer at the next edge.
    always_comb expired = run && (cnt == LAST);

    // R4: the count never goes past its final value.
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R6: a cycle without run always leaves the counter at zero.
    p_cnt_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0));

endmodule

// File: rtl/seq_ctrl.sv
// Module: seq_ctrl - state machine of the power-up sequencer.
// Steps through idle, supply wait, clock wait, hold, released and fault.
// It drives the enables and the reset, and it tells the two counters
// when to run. The reset output is also gated by both status inputs, so
// a lost status pulls it low in the same cycle.
// Assumes: pwr_ok and clk_ok are synchronous to clk.
module seq_ctrl
    import fundrst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic pwr_ok,
    input  logic clk_ok,
    input  logic hold_done,
    input  logic tmo_hit,
    output logic hold_run,
    output logic tmo_run,
    output logic pwr_en,
    output logic refclk_en,
    output logic perst_n,
    output logic done,
    output logic timeout
);
    seq_state_e state, state_nx;
    logic       both_ok;

    always_comb both_ok = pwr_ok && clk_ok;

    // Next-state decision.
    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_IDLE:     if (start_req) state_nx = SEQ_PWR_WAIT;
            SEQ_PWR_WAIT: begin
                if (pwr_ok)       state_nx = SEQ_CLK_WAIT;
                else if (tmo_hit) state_nx = SEQ_FAULT;
            end
            SEQ_CLK_WAIT: begin
                if (!pwr_ok)      state_nx = SEQ_PWR_WAIT;
                else if (clk_ok)  state_nx = SEQ_HOLD;
                else if (tmo_hit) state_nx = SEQ_FAULT;
            end
            SEQ_HOLD: begin
                if (!both_ok)       state_nx = SEQ_PWR_WAIT;
                else if (hold_done) state_nx = SEQ_RUN;
            end
            SEQ_RUN:      if (!both_ok) state_nx = SEQ_PWR_WAIT;
            SEQ_FAULT:    state_nx = SEQ_FAULT;
            default:      state_nx = SEQ_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= state_nx;
    end

    // Counter run controls: each clears on the cycle its wait ends.
    always_comb begin
        hold_run = (state == SEQ_HOLD) && both_ok;
        tmo_run  = ((state == SEQ_PWR_WAIT) && !pwr_ok) ||
                   ((state == SEQ_CLK_WAIT) && pwr_ok && !clk_ok);
    end

    // Output decode from state, with reset gated by live status.
    always_comb begin
        pwr_en    = (state == SEQ_PWR_WAIT) || (state == SEQ_CLK_WAIT) ||
                    (state == SEQ_HOLD)     || (state == SEQ_RUN);
        refclk_en = (state == SEQ_CLK_WAIT) || (state == SEQ_HOLD) ||
                    (state == SEQ_RUN);
        perst_n   = (state == SEQ_RUN) && both_ok;
        done      = perst_n;
        timeout   = (state == SEQ_FAULT);
    end

    // R2: the clock is never enabled without the supply.
    p_clk_needs_pwr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        refclk_en |-> pwr_en);

    // R3: the clock enable rises only after the supply was seen stable.
    p_clk_after_pwr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(refclk_en) |-> $past(pwr_ok));

    // R6: losing a status input in the released state restarts the supply wait.
    p_drop_restarts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_RUN && !both_ok) |=> (state == SEQ_PWR_WAIT));

    // R7: the fault state is sticky.
    p_fault_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> timeout);

    // R7: in fault, the card stays in reset with both enables off.
    p_fault_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (!perst_n && !pwr_en && !refclk_en));

endmodule

// File: rtl/fundrst_powerup_seq.sv
// Module: fundrst_powerup_seq - top of the fundamental-reset power-up
// sequencer. Converts the delay parameters to cycles and joins the state
// machine to a hold counter and a status-timeout counter.
// The hold is max(supply delay, clock delay), counted from clock stable.
// Assumes: status inputs are synchronous to clk, reset is synchronous
// and active low.
module fundrst_powerup_seq #(
    parameter int unsigned CLK_HZ      = 100_000_000,
    parameter int unsigned PWR_HOLD_US = 100_000,
    parameter int unsigned CLK_HOLD_US = 100,
    parameter int unsigned STAT_TMO_US = 50_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic pwr_good_i,
    input  logic refclk_ok_i,
    output logic pwr_en_o,
    output logic refclk_en_o,
    output logic perst_n_o,
    output logic done_o,
    output logic timeout_o
);
    import fundrst_pkg::*;

    localparam int unsigned PWR_CYC  = us_to_cycles(CLK_HZ, PWR_HOLD_US);
    localparam int unsigned CLK_CYC  = us_to_cycles(CLK_HZ, CLK_HOLD_US);
    localparam int unsigned HOLD_CYC = (PWR_CYC > CLK_CYC) ? PWR_CYC : CLK_CYC;
    localparam int unsigned TMO_CYC  = us_to_cycles(CLK_HZ, STAT_TMO_US);

    logic hold_run, hold_done;
    logic tmo_run, tmo_hit;

    seq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .pwr_ok    (pwr_good_i),
        .clk_ok    (refclk_ok_i),
        .hold_done (hold_done),
        .tmo_hit   (tmo_hit),
        .hold_run  (hold_run),
        .tmo_run   (tmo_run),
        .pwr_en    (pwr_en_o),
        .refclk_en (refclk_en_o),
        .perst_n   (perst_n_o),
        .done      (done_o),
        .timeout   (timeout_o)
    );

    seq_cnt #(.LIMIT(HOLD_CYC)) u_hold_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (hold_run),
        .expired (hold_done)
    );

    seq_cnt #(.LIMIT(TMO_CYC)) u_tmo_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmo_run),
        .expired (tmo_hit)
    );

    // R1: the first cycle out of reset shows a quiet slot.
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!perst_n_o && !pwr_en_o && !refclk_en_o && !timeout_o));

    // R4: release follows only a completed hold count.
    p_release_after_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(perst_n_o) |-> $past(hold_done));

    // R8: a timeout is raised only at the end of a status wait.
    p_timeout_from_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> $past(tmo_hit));

endmodule

// File: tb/fundrst_powerup_seq_tb.sv
// Scoreboard bench: the driver queues the expected output vectors
// {pwr_en, refclk_en, perst_n, done, timeout}, each stamped with the cycle
// it belongs to. A monitor pops and compares them at the falling edge.
module fundrst_powerup_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 40;   // max(40 us, 5 us) at 1 MHz
    localparam int TMO  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_req = 1'b0;
    logic pwr_good = 1'b0;
    logic refclk_ok = 1'b0;
    logic pwr_en, refclk_en, perst_n, done, timeout;

    fundrst_powerup_seq #(
        .CLK_HZ(1_000_000), .PWR_HOLD_US(40), .CLK_HOLD_US(5), .STAT_TMO_US(20)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req),
        .pwr_good_i(pwr_good), .refclk_ok_i(refclk_ok),
        .pwr_en_o(pwr_en), .refclk_en_o(refclk_en), .perst_n_o(perst_n),
        .done_o(done), .timeout_o(timeout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int         at;
        logic [4:0] v;
        string      tag;
    } exp_t;

    exp_t q[$];
    exp_t e;
    int n_cmp = 0;
    int n_bad = 0;

    task automatic expect_at(input int at, input logic [4:0] v, input string tag);
        exp_t x;
        x.at = at; x.v = v; x.tag = tag;
        q.push_back(x);
    endtask

    task automatic step_to(input int n);
        while (cyc < n) begin
            @(posedge clk);
            #1;
        end
    endtask

    // Monitor: compare every item due in this cycle.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].at <= cyc) begin
            e = q.pop_front();
            n_cmp++;
            if (e.at != cyc || {pwr_en, refclk_en, perst_n, done, timeout} !== e.v) begin
                n_bad++;
                $display("FAIL %s cycle %0d (due %0d): got %b expected %b",
                         e.tag, cyc, e.at,
                         {pwr_en, refclk_en, perst_n, done, timeout}, e.v);
            end
        end
    end

    initial begin
        int c;
        @(posedge clk); #1;
        // R1: quiet while in reset and just after it.
        expect_at(2, 5'b00000, "R1");
        expect_at(5, 5'b00000, "R1");
        step_to(3);
        rst_n = 1'b1;
        step_to(6);

        // Normal sequence (R2, R3, R4, R9) with a stray start (R10).
        c = cyc;
        expect_at(c + 1, 5'b10000, "R2");
        expect_at(c + 3, 5'b10000, "R2");
        expect_at(c + 4, 5'b11000, "R3");
        expect_at(c + 12, 5'b11000, "R10");
        expect_at(c + 7 + HOLD - 1, 5'b11000, "R4");
        expect_at(c + 7 + HOLD, 5'b11110, "R4");
        expect_at(c + 7 + HOLD + 3, 5'b11110, "R9");
        start_req = 1'b1;
        step_to(c + 1);  start_req = 1'b0;
        step_to(c + 3);  pwr_good = 1'b1;
        step_to(c + 6);  refclk_ok = 1'b1;
        step_to(c + 10); start_req = 1'b1;
        step_to(c + 11); start_req = 1'b0;
        step_to(c + 7 + HOLD + 4);

        // Clock lost while released (R5, R6, R9).
        c = cyc;
        expect_at(c, 5'b11000, "R5");
        expect_at(c + 1, 5'b10000, "R6");
        expect_at(c + 2, 5'b11000, "R6");
        expect_at(c + 4 + HOLD - 1, 5'b11000, "R6");
        expect_at(c + 4 + HOLD, 5'b11110, "R9");
        refclk_ok = 1'b0;
        step_to(c + 3); refclk_ok = 1'b1;
        step_to(c + 4 + HOLD + 2);

        // Supply lost while released, then again mid-hold (R5, R6).
        c = cyc;
        expect_at(c, 5'b11000, "R5");
        expect_at(c + 1, 5'b10000, "R6");
        expect_at(c + 3, 5'b11000, "R6");
        expect_at(c + 15, 5'b10000, "R6");
        expect_at(c + 4 + HOLD, 5'b11000, "R6");
        expect_at(c + 17 + HOLD - 1, 5'b11000, "R6");
        expect_at(c + 17 + HOLD, 5'b11110, "R4");
        pwr_good = 1'b0;
        step_to(c + 2);  pwr_good = 1'b1;
        step_to(c + 14); pwr_good = 1'b0;
        step_to(c + 15); pwr_good = 1'b1;
        step_to(c + 17 + HOLD + 2);

        // Reset in the middle of a released state (R1).
        c = cyc;
        expect_at(c + 1, 5'b00000, "R1");
        rst_n = 1'b0;
        step_to(c + 2);
        rst_n = 1'b1; pwr_good = 1'b0; refclk_ok = 1'b0;
        step_to(c + 4);

        // Supply never arrives (R7), then later stimulus is ignored.
        c = cyc;
        expect_at(c + TMO, 5'b10000, "R7");
        expect_at(c + TMO + 1, 5'b00001, "R7");
        expect_at(c + TMO + 12, 5'b00001, "R7");
        start_req = 1'b1;
        step_to(c + 1); start_req = 1'b0;
        step_to(c + TMO + 3); pwr_good = 1'b1; refclk_ok = 1'b1; start_req = 1'b1;
        step_to(c + TMO + 4); start_req = 1'b0;
        step_to(c + TMO + 13);
        c = cyc;
        expect_at(c + 1, 5'b00000, "R1");
        rst_n = 1'b0; refclk_ok = 1'b0;
        step_to(c + 2); rst_n = 1'b1;
        step_to(c + 3);

        // Clock never arrives (R8).
        c = cyc;
        expect_at(c + 1, 5'b10000, "R8");
        expect_at(c + 2, 5'b11000, "R8");
        expect_at(c + 1 + TMO, 5'b11000, "R8");
        expect_at(c + 2 + TMO, 5'b00001, "R8");
        start_req = 1'b1;
        step_to(c + 1); start_req = 1'b0;
        step_to(c + TMO + 5);

        if (q.size() > 0) begin
            n_bad += q.size();
            n_cmp += q.size();
            $display("FAIL pending checks left: got %0d expected 0", q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got no finish, expected one before 5000 cycles");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule